// File: doc/BRIEF.md
# DMA Channel Event Latch Bank

This block gathers synchronization event pulses for a bank of DMA channels (64 by default). Each pulse sets a per-channel pending flag, whether or not the channel is enabled. An enable mask decides which pending flags compete for service. A priority picker offers one winning channel index to a downstream queue and holds it under a valid/ready handshake. When the queue accepts the request, the block drops that channel's pending flag.

If an event lands on an enabled channel whose flag is already raised, one event has been lost. The block records this in a per-channel miss flag. Software reaches the flags through a flat 32-bit register port. Each 64-bit quantity is split into a low word for channels 0..31 and a high word for channels 32..63. Software can set and clear enables, and it can clear pending and miss flags by writing ones.

Top module: `dma_evt_latch_bank`

## Requirements
- R1: Register word address is {kind[2:0], word}. Word 0 carries channels 0..31 and word 1 carries channels 32..63. Bit position within the word equals the channel number modulo 32.
- R2: An event pulse on a channel sets its pending flag at the next clock edge, regardless of that channel's enable bit.
- R3: Only channels that are both pending and enabled are ever offered on the request port. A disabled pending channel stays pending.
- R4: Among eligible channels, the lowest channel number is offered first. Once `req_valid` is high, `req_valid` and `req_ch` stay unchanged until `req_ready` is seen high.
- R5: A handshake (`req_valid` and `req_ready` high at a clock edge) clears the offered channel's pending flag at that edge. The next eligible channel is offered from the following cycle.
- R6: An event on a channel that is already pending and enabled sets that channel's miss flag. An event on a pending but disabled channel leaves the miss flag alone.
- R7: Writing 1 to a bit of the pending-clear register (kind 1) clears that pending flag. Bits written as 0 have no effect.
- R8: When an event and a clear (software write or handshake) hit the same channel in the same cycle, the pending flag ends up 1. If the flag was 1 before and the channel is enabled, the miss flag is also set.
- R9: Writing ones to the enable-set register (kind 3) sets enable bits, and writing ones to the enable-clear register (kind 4) clears them. Writing ones to the miss-clear register (kind 6) clears miss flags. Bits written as 0 have no effect.
- R10: The following kinds read back live state: pending (kind 0), enable (kind 2) and miss (kind 5). Kinds 1, 3, 4, 6 and 7 read as zero. Writes to kinds 0, 2, 5 and 7 are ignored.
- R11: After reset, all pending, enable and miss flags are zero and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| evt_i | input | NUM_CH | One-cycle event pulses, one per channel, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address {kind, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | output | 1 | A channel request is offered |
| req_ch | output | CH_W | Offered channel number |
| req_ready | input | 1 | Queue accepts the offered request |

## Verification
A corrupted pending flag shows up at the ports in two ways. It changes the pending word read at the next cycle. For an enabled channel, it also causes a wrong or missing request within two edges, because the picker registers its choice one edge after the flags settle. A wrong enable or miss flag becomes visible on the next register read. A faulty priority or hold shows up as an out-of-order `req_ch` when a known mask is drained, because every accepted request is compared against the lowest remaining channel of a mask the bench computes itself.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_PEND  = 3'd0,
    K_PCLR  = 3'd1,
    K_EN    = 3'd2,
    K_ENSET = 3'd3,
    K_ENCLR = 3'd4,
    K_MISS  = 3'd5,
    K_MCLR  = 3'd6,
    K_NONE  = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/dma_evt_regif.sv
module dma_evt_regif
  import dma_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] miss_i,
  output logic [NUM_CH-1:0] pclr_o,
  output logic [NUM_CH-1:0] enset_o,
  output logic [NUM_CH-1:0] enclr_o,
  output logic [NUM_CH-1:0] mclr_o
);
  localparam int unsigned NUM_WORDS = NUM_CH / WORD_W;
  localparam int unsigned WSEL_W    = ADDR_W - KIND_W;

  reg_kind_e         kind;
  logic [WSEL_W-1:0] wsel;

  assign kind = reg_kind_e'(reg_addr[ADDR_W-1 -: KIND_W]);
  assign wsel = reg_addr[WSEL_W-1:0];

  // Write strobes fan out one word slice at a time.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = reg_we && (wsel == WSEL_W'(w));
    assign pclr_o [w*WORD_W +: WORD_W] = (hit && kind == K_PCLR ) ? reg_wdata : '0;
    assign enset_o[w*WORD_W +: WORD_W] = (hit && kind == K_ENSET) ? reg_wdata : '0;
    assign enclr_o[w*WORD_W +: WORD_W] = (hit && kind == K_ENCLR) ? reg_wdata : '0;
    assign mclr_o [w*WORD_W +: WORD_W] = (hit && kind == K_MCLR ) ? reg_wdata : '0;
  end

  always_comb begin
    unique case (kind)
      K_PEND:  reg_rdata = pend_i[wsel*WORD_W +: WORD_W];
      K_EN:    reg_rdata = en_i  [wsel*WORD_W +: WORD_W];
      K_MISS:  reg_rdata = miss_i[wsel*WORD_W +: WORD_W];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_evt_state.sv
module dma_evt_state #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic [NUM_CH-1:0] pclr_i,
  input  logic [NUM_CH-1:0] svc_clr_i,
  input  logic [NUM_CH-1:0] enset_i,
  input  logic [NUM_CH-1:0] enclr_i,
  input  logic [NUM_CH-1:0] mclr_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] miss_o
);
  logic [NUM_CH-1:0] pend_q, pend_n;
  logic [NUM_CH-1:0] en_q,   en_n;
  logic [NUM_CH-1:0] miss_q, miss_n;
  logic [NUM_CH-1:0] lost;
  logic              pend_ce, en_ce, miss_ce;

  // Set terms are OR-ed last so that an event outranks any clear.
  always_comb begin
    lost    = evt_i & pend_q & en_q;
    pend_n  = (pend_q & ~(pclr_i | svc_clr_i)) | evt_i;
    en_n    = (en_q & ~enclr_i) | enset_i;
    miss_n  = (miss_q & ~mclr_i) | lost;
    pend_ce = |(evt_i | pclr_i | svc_clr_i);
    en_ce   = |(enset_i | enclr_i);
    miss_ce = |(lost | mclr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      miss_q <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_n;
      if (en_ce)   en_q   <= en_n;
      if (miss_ce) miss_q <= miss_n;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign miss_o = miss_q;

  // R2 / R8: every pulsed channel is pending one edge later.
  p_evt_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R5 / R7: a clear without a coincident event drops the flag.
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pclr_i | svc_clr_i) & ~evt_i) != '0)
      |=> ((pend_q & $past((pclr_i | svc_clr_i) & ~evt_i)) == '0));

  // R6 / R8: collision with a pending enabled channel records a miss.
  p_collision_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & pend_q & en_q) != '0)
      |=> ((miss_q & $past(evt_i & pend_q & en_q)) == $past(evt_i & pend_q & en_q)));

  // R6: a disabled channel never gains a miss flag.
  p_no_miss_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ~en_q & ~miss_q) != '0)
      |=> ((miss_q & $past(evt_i & ~en_q & ~miss_q)) == '0));
endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cand_i,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [CH_W-1:0]   req_ch,
  output logic [NUM_CH-1:0] svc_clr_o
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic              valid_q, valid_n;
  logic [CH_W-1:0]   ch_q, ch_n, pick;
  logic [NUM_CH-1:0] cand_m;
  logic              accept, load, found;

  assign accept    = valid_q && req_ready;
  assign load      = !valid_q || req_ready;
  assign svc_clr_o = accept ? (ONE << ch_q) : '0;
  // The channel being served this edge is not eligible for the reload.
  assign cand_m    = cand_i & ~svc_clr_o;
  assign found     = |cand_m;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand_m[i]) pick = CH_W'(i);
    end
  end

  always_comb begin
    valid_n = valid_q;
    ch_n    = ch_q;
    if (load) begin
      valid_n = found;
      ch_n    = found ? pick : ch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
    end else if (load) begin
      valid_q <= valid_n;
      ch_q    <= ch_n;
    end
  end

  assign req_valid = valid_q;
  assign req_ch    = ch_q;

  // R4: an offer is held until accepted.
  p_hold_until_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !req_ready) |=> (valid_q && $stable(ch_q)));

  // R3: a newly loaded channel was pending and enabled.
  p_offer_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && found) |=> (valid_q && ((($past(cand_m) >> ch_q) & ONE) == ONE)));

  // R4: nothing below the loaded channel was eligible.
  p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && found) |=> (($past(cand_m) & ((ONE << ch_q) - ONE)) == '0));

  // R5: with nothing eligible, the offer is withdrawn after acceptance.
  p_idle_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !found) |=> !valid_q);
endmodule

// File: rtl/dma_evt_latch_bank.sv
module dma_evt_latch_bank
  import dma_evt_pkg::*;
#(
  parameter int unsigned NUM_CH    = 64,
  parameter int unsigned NUM_WORDS = NUM_CH / WORD_W,
  parameter int unsigned ADDR_W    = KIND_W + $clog2(NUM_WORDS),
  parameter int unsigned CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              req_valid,
  output logic [CH_W-1:0]   req_ch,
  input  logic              req_ready
);
  logic [NUM_CH-1:0] pend, en, miss;
  logic [NUM_CH-1:0] pclr, enset, enclr, mclr, svc_clr;

  dma_evt_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pend_i   (pend),
    .en_i     (en),
    .miss_i   (miss),
    .pclr_o   (pclr),
    .enset_o  (enset),
    .enclr_o  (enclr),
    .mclr_o   (mclr)
  );

  dma_evt_state #(.NUM_CH(NUM_CH)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .pclr_i   (pclr),
    .svc_clr_i(svc_clr),
    .enset_i  (enset),
    .enclr_i  (enclr),
    .mclr_i   (mclr),
    .pend_o   (pend),
    .en_o     (en),
    .miss_o   (miss)
  );

  dma_evt_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_i   (pend & en),
    .req_ready(req_ready),
    .req_valid(req_valid),
    .req_ch   (req_ch),
    .svc_clr_o(svc_clr)
  );
endmodule

// File: tb/tb_dma_evt_latch_bank.sv
module tb_dma_evt_latch_bank;
  localparam int NCH = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  evt_i;
  logic            reg_we;
  logic [3:0]      reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            req_valid;
  logic [5:0]      req_ch;
  logic            req_ready;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_evt_latch_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ch(req_ch), .req_ready(req_ready)
  );

  // Address = kind*2 + word
  localparam logic [3:0] A_PEND = 4'd0, A_PCLR = 4'd2, A_EN = 4'd4, A_ENSET = 4'd6,
                         A_ENCLR = 4'd8, A_MISS = 4'd10, A_MCLR = 4'd12, A_NONE = 4'd14;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr64(input logic [3:0] a, input logic [63:0] d);
    wr(a, d[31:0]);
    wr(a + 4'd1, d[63:32]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd64(input logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic pulse(input logic [63:0] v);
    evt_i = v;
    tick();
    evt_i = '0;
  endtask

  function automatic int lowest(input logic [63:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return -1;
  endfunction

  // Drain all eligible channels, checking ascending order (R4, R5).
  task automatic drain(input logic [63:0] elig, input string req);
    logic [63:0] m = elig;
    int w = 0;
    req_ready = 1'b1;
    while (!req_valid && w < 4) begin tick(); w++; end
    while (m != 0) begin
      chk({req, " offer"}, {57'd0, req_valid, req_ch}, {57'd0, 1'b1, 6'(lowest(m))});
      m[lowest(m)] = 1'b0;
      tick();
    end
    req_ready = 1'b0;
    chk({req, " idle after drain"}, {63'd0, req_valid}, 64'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] v, acc, p, e;
    logic [31:0] d;
    logic [63:0] seed;
    rst_n = 1'b0; evt_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; req_ready = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R11 / R10: reset state, every address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R11 reset read", {32'd0, d}, 64'd0);
    end
    chk("R11 req_valid after reset", {63'd0, req_valid}, 64'd0);

    // R2 / R1 / R3: channel sweep with all disabled
    acc = '0;
    for (int c = 0; c < NCH; c++) begin
      pulse(64'd1 << c);
      acc[c] = 1'b1;
      rd(A_PEND, d);         chk("R1 R2 pend low word", {32'd0, d}, {32'd0, acc[31:0]});
      rd(A_PEND + 4'd1, d);  chk("R1 R2 pend high word", {32'd0, d}, {32'd0, acc[63:32]});
      chk("R3 no offer while disabled", {63'd0, req_valid}, 64'd0);
    end
    // R6: collision on a disabled channel: no miss
    pulse(64'd1 << 5);
    rd64(A_MISS, v); chk("R6 no miss when disabled", v, 64'd0);
    // R7: writing zero to clear changes nothing
    wr64(A_PCLR, 64'd0);
    rd64(A_PEND, v); chk("R7 zero clear ignored", v, acc);
    // R10: writes to read-only kinds ignored
    wr64(A_PEND, 64'd0); wr64(A_MISS, 64'hFFFF_FFFF_FFFF_FFFF); wr(A_NONE, 32'hFFFF_FFFF);
    rd64(A_PEND, v); chk("R10 pend write ignored", v, acc);
    rd64(A_MISS, v); chk("R10 miss write ignored", v, 64'd0);
    // R7: partial clear then full clear
    wr(A_PCLR + 4'd1, 32'h0000_FFFF);
    rd64(A_PEND, v); chk("R7 partial clear", v, 64'hFFFF_0000_FFFF_FFFF);
    wr64(A_PCLR, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(A_PEND, v); chk("R7 full clear", v, 64'd0);

    // R9 / R10: enable set and clear
    wr(A_ENSET, 32'hA5A5_0F0F);
    rd(A_EN, d); chk("R9 enable set", {32'd0, d}, 64'h0000_0000_A5A5_0F0F);
    wr(A_ENCLR, 32'h0000_0F00);
    rd(A_EN, d); chk("R9 enable clear", {32'd0, d}, 64'h0000_0000_A5A5_000F);
    rd(A_ENSET, d); chk("R10 enable-set reads zero", {32'd0, d}, 64'd0);
    rd(A_ENCLR, d); chk("R10 enable-clear reads zero", {32'd0, d}, 64'd0);
    rd(A_PCLR, d); chk("R10 pend-clear reads zero", {32'd0, d}, 64'd0);
    rd(A_MCLR, d); chk("R10 miss-clear reads zero", {32'd0, d}, 64'd0);

    // R4 / R5: priority drain over several masks, all enabled
    wr64(A_ENSET, 64'hFFFF_FFFF_FFFF_FFFF);
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 11; k++) begin
      if (k == 0) p = 64'h1;
      else if (k == 1) p = 64'h8000_0000_0000_0000;
      else if (k == 2) p = 64'hFFFF_FFFF_FFFF_FFFF;
      else begin
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
        p = seed;
      end
      pulse(p);
      drain(p, "R4 R5 priority");
      rd64(A_PEND, v); chk("R5 pend empty after drain", v, 64'd0);
    end

    // R3: partial enable mask
    wr64(A_ENCLR, 64'hFFFF_FFFF_FFFF_FFFF);
    e = 64'h00FF_00FF_00FF_00FF;
    wr64(A_ENSET, e);
    p = 64'hF0F0_F0F0_F0F0_F0F0;
    pulse(p);
    drain(p & e, "R3 masked");
    rd64(A_PEND, v); chk("R3 disabled stay pending", v, p & ~e);
    wr64(A_PCLR, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4 hold, R6 collision, R9 miss clear
    wr64(A_ENCLR, 64'hFFFF_FFFF_FFFF_FFFF);
    wr64(A_ENSET, (64'd1 << 40) | (64'd1 << 3));
    pulse(64'd1 << 40);
    tick();
    chk("R4 offer ch40", {57'd0, req_valid, req_ch}, {57'd0, 1'b1, 6'd40});
    pulse(64'd1 << 40);
    rd64(A_MISS, v); chk("R6 collision miss", v, 64'd1 << 40);
    pulse(64'd1 << 3);
    tick(); tick();
    chk("R4 held despite lower channel", {57'd0, req_valid, req_ch}, {57'd0, 1'b1, 6'd40});
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    chk("R5 next offer ch3", {57'd0, req_valid, req_ch}, {57'd0, 1'b1, 6'd3});
    rd64(A_PEND, v); chk("R5 ch40 served", v, 64'd1 << 3);
    wr(A_MCLR + 4'd1, 32'd0);
    rd64(A_MISS, v); chk("R9 zero miss-clear ignored", v, 64'd1 << 40);
    wr(A_MCLR + 4'd1, 32'h0000_0100);
    rd64(A_MISS, v); chk("R9 miss clear", v, 64'd0);

    // R8: event beats handshake clear on ch3 (pending, enabled)
    req_ready = 1'b1; evt_i = 64'd1 << 3;
    tick();
    req_ready = 1'b0; evt_i = '0;
    rd64(A_PEND, v); chk("R8 set beats service clear", v, 64'd1 << 3);
    rd64(A_MISS, v); chk("R8 lost event recorded", v, 64'd1 << 3);
    wr64(A_MCLR, 64'hFFFF_FFFF_FFFF_FFFF);

    // R8: event beats software clear, flag previously 0 (ch20 disabled)
    evt_i = 64'd1 << 20; reg_we = 1'b1; reg_addr = A_PCLR; reg_wdata = 32'h0010_0000;
    tick();
    evt_i = '0; reg_we = 1'b0;
    rd64(A_PEND, v); chk("R8 set beats sw clear", v & (64'd1 << 20), 64'd1 << 20);
    rd64(A_MISS, v); chk("R8 no miss when previously clear", v, 64'd0);
    // R8: flag previously 1 and enabled
    wr(A_ENSET, 32'h0010_0000);
    evt_i = 64'd1 << 20; reg_we = 1'b1; reg_addr = A_PCLR; reg_wdata = 32'h0010_0000;
    tick();
    evt_i = '0; reg_we = 1'b0;
    rd64(A_PEND, v); chk("R8 pend kept on collision", v & (64'd1 << 20), 64'd1 << 20);
    rd64(A_MISS, v); chk("R8 miss on collision with clear", v, 64'd1 << 20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule